// File: doc/BRIEF.md
# Programmable Parallel Port Register Controller

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a small register interface. The interface has active-low chip select, read strobe and write strobe, a 2-bit register address, and separate 8-bit buses for write data and read data. Each port has an output register, a set of output enables and a set of input pins. Software sets the direction of each port group with a control word. A second format of the control word sets or clears one bit of port C without touching the direction setup.

Only static input/output behaviour is built. The two mode fields in the control word are stored and can be read back, but every mode value acts like the basic static mode. Port C is split into an upper and a lower nibble, and each nibble has its own direction. Everything runs on one clock, and all state changes on its rising edge.

Top module: `ppio_ctrl`

## Requirements
- R1: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register. A write to address 0, 1 or 2 loads the whole byte into that port's output register, and that register drives `a_out`, `b_out` or `c_out`.
- R2: A write to address 3 with `din[7]=1` is a mode definition and is stored whole as the control word. The direction bits are: bit 4 = 1 makes port A an input, bit 3 = 1 makes C[7:4] an input, bit 1 = 1 makes port B an input, and bit 0 = 1 makes C[3:0] an input. A direction bit of 0 asserts the matching enables: `a_oe`, `b_oe`, `c_oe[7:4]` or `c_oe[3:0]`.
- R3: A write to address 3 with `din[7]=0` sets one port C output bit. Bits 3..1 give the bit number and bit 0 gives its new value. The write leaves the control word, every output enable and the other seven port C bits unchanged.
- R4: After reset the control word reads 0x00, every output register is 0 and every output enable is 0, so all ports are inputs until the first mode definition.
- R5: A mode definition write clears the port A, B and C output registers to 0.
- R6: A read of a port set as input returns its live input pins. A read of a port set as output returns its output register. Port C is resolved separately for each nibble.
- R7: A read of address 3 returns the stored control word. `dout` is 0 whenever `cs_n` or `rd_n` is high.
- R8: A write has no effect while `cs_n` is high.
- R9: A write is captured on the first rising edge at which `cs_n` and `wr_n` are both low. It is captured only once for each low pulse of `wr_n`, even if `din` or `addr` changes later in the pulse.
- R10: The mode fields, bits 6..5 for group A and bit 2 for group B, read back as written, but they have no effect on direction or data. Every mode value behaves like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when no read is active |
| a_in | input | 8 | Port A input pins |
| b_in | input | 8 | Port B input pins |
| c_in | input | 8 | Port C input pins |
| a_out | output | 8 | Port A output register |
| a_oe | output | 1 | Port A output enable |
| b_out | output | 8 | Port B output register |
| b_oe | output | 1 | Port B output enable |
| c_out | output | 8 | Port C output register |
| c_oe | output | 8 | Port C per-bit output enables |

## Verification
On every cycle the assertions check four things:
- `dout` is 0 when no read is active.
- The two nibbles of `c_oe` each stay all-set or all-clear.
- A set/reset command leaves the enables alone.
- A held write strobe causes no second capture.

They also check the state just after reset. Only the bench scenarios can show that the correct value lands in the correct register. Those scenarios sweep all 128 mode words, all 16 set/reset commands, reads of live pins against register reads nibble by nibble, and a write attempted with chip select high.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int DW       = 8;
    localparam int AW       = 2;
    localparam int NIB      = DW / 2;
    localparam int SEL_W    = $clog2(DW);
    // command word bit positions
    localparam int CW_FMT   = 7;
    localparam int CW_A_IN  = 4;
    localparam int CW_CU_IN = 3;
    localparam int CW_B_IN  = 1;
    localparam int CW_CL_IN = 0;

    typedef enum logic [AW-1:0] {
        REG_A   = 2'd0,
        REG_B   = 2'd1,
        REG_C   = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          cfg;
        logic [DW-1:0] pa;
        logic [DW-1:0] pb;
        logic [DW-1:0] pc;
    } ppio_state_t;
endpackage

// File: rtl/ppio_wr_gate.sv
module ppio_wr_gate (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_fire
);
    logic seen_d, seen_q;

    always_comb begin
        wr_fire = !cs_n && !wr_n && !seen_q;
        seen_d  = !wr_n && (seen_q || !cs_n);
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end
endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    output ppio_state_t       st
);
    ppio_state_t st_d, st_q;
    logic [SEL_W-1:0] bit_sel;

    always_comb begin
        st_d    = st_q;
        bit_sel = din[SEL_W:1];
        if (wr_fire) begin
            unique case (reg_sel_e'(addr))
                REG_A: st_d.pa = din;
                REG_B: st_d.pb = din;
                REG_C: st_d.pc = din;
                REG_CTL: begin
                    if (din[CW_FMT]) begin
                        st_d.ctrl = din;
                        st_d.cfg  = 1'b1;
                        st_d.pa   = '0;
                        st_d.pb   = '0;
                        st_d.pc   = '0;
                    end else begin
                        st_d.pc[bit_sel] = din[0];
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/ppio_dir.sv
module ppio_dir
    import ppio_pkg::*;
(
    input  ppio_state_t   st,
    output logic          a_oe,
    output logic          b_oe,
    output logic [DW-1:0] c_oe
);
    always_comb begin
        a_oe = st.cfg && !st.ctrl[CW_A_IN];
        b_oe = st.cfg && !st.ctrl[CW_B_IN];
    end

    for (genvar g = 0; g < 2; g++) begin : g_cnib
        localparam int DBIT = (g == 0) ? CW_CL_IN : CW_CU_IN;
        assign c_oe[g*NIB +: NIB] = {NIB{st.cfg && !st.ctrl[DBIT]}};
    end
endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
    import ppio_pkg::*;
(
    input  ppio_state_t   st,
    input  logic          rd_act,
    input  logic [AW-1:0] addr,
    input  logic          a_oe,
    input  logic          b_oe,
    input  logic [DW-1:0] c_oe,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] a_view, b_view, c_view;

    always_comb begin
        a_view = a_oe ? st.pa : a_in;
        b_view = b_oe ? st.pb : b_in;
        for (int i = 0; i < DW; i++) begin
            c_view[i] = c_oe[i] ? st.pc[i] : c_in[i];
        end
        dout = '0;
        if (rd_act) begin
            unique case (reg_sel_e'(addr))
                REG_A:   dout = a_view;
                REG_B:   dout = b_view;
                REG_C:   dout = c_view;
                REG_CTL: dout = st.ctrl;
                default: dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    output logic [DW-1:0] b_out,
    output logic          b_oe,
    output logic [DW-1:0] c_out,
    output logic [DW-1:0] c_oe
);
    logic        wr_fire;
    logic        rd_act;
    ppio_state_t st;

    assign rd_act = !cs_n && !rd_n;

    ppio_wr_gate u_wr_gate (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .wr_fire (wr_fire)
    );

    ppio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .addr    (addr),
        .din     (din),
        .st      (st)
    );

    ppio_dir u_dir (
        .st   (st),
        .a_oe (a_oe),
        .b_oe (b_oe),
        .c_oe (c_oe)
    );

    ppio_rd_mux u_rd_mux (
        .st     (st),
        .rd_act (rd_act),
        .addr   (addr),
        .a_oe   (a_oe),
        .b_oe   (b_oe),
        .c_oe   (c_oe),
        .a_in   (a_in),
        .b_in   (b_in),
        .c_in   (c_in),
        .dout   (dout)
    );

    assign a_out = st.pa;
    assign b_out = st.pb;
    assign c_out = st.pc;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic [7:0] a_out,
    input logic       a_oe,
    input logic [7:0] b_out,
    input logic       b_oe,
    input logic [7:0] c_out,
    input logic [7:0] c_oe
);
    AST_IDLE_DOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (dout == 8'h00)) else $error("idle dout"); // R7

    AST_CNIB_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        ((c_oe[7:4] == 4'h0) || (c_oe[7:4] == 4'hF)) &&
        ((c_oe[3:0] == 4'h0) || (c_oe[3:0] == 4'hF))) else $error("c_oe nibble"); // R2

    AST_BITCMD_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && addr == 2'd3 && !din[7]) |=>
        ($stable(a_oe) && $stable(b_oe) && $stable(c_oe))) else $error("bitcmd dir"); // R3

    AST_HELD_WR_ONCE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!cs_n && !wr_n) && !wr_n) |=>
        ($stable(a_out) && $stable(b_out) && $stable(c_out))) else $error("held write"); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!a_oe && !b_oe && c_oe == 8'h00 && c_out == 8'h00)) else $error("reset state"); // R4
endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .addr  (addr),
    .din   (din),
    .dout  (dout),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_out (b_out),
    .b_oe  (b_oe),
    .c_out (c_out),
    .c_oe  (c_oe)
);

// File: tb/ppio_ctrl_bench.sv
`timescale 1ns/1ps
module ppio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout, a_in = '0, b_in = '0, c_in = '0;
    logic [7:0] a_out, b_out, c_out, c_oe;
    logic       a_oe, b_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ppio_ctrl u_ppio_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .c_out(c_out), .c_oe(c_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] r);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 r = dout;
        rd_n = 1'b1; cs_n = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] r, ea, eb, ec, cw, pc_m;
        logic       oa, ob, ocu, ocl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        check("R4 a_oe", {7'd0, a_oe}, 8'h00);
        check("R4 b_oe", {7'd0, b_oe}, 8'h00);
        check("R4 c_oe", c_oe, 8'h00);
        check("R4 c_out", c_out, 8'h00);
        check("R4 a_out", a_out, 8'h00);
        rd(2'd3, r); check("R4 ctrl", r, 8'h00);
        a_in = 8'h5A;
        rd(2'd0, r); check("R4 A reads pins", r, 8'h5A);
        #1 check("R7 idle dout", dout, 8'h00);

        // sweep every mode definition word
        for (int k = 0; k < 128; k++) begin
            cw = 8'h80 | k[7:0];
            wr(2'd1, 8'hFF);                       // dirty B before mode write
            wr(2'd3, cw);
            oa = !cw[4]; ob = !cw[1]; ocu = !cw[3]; ocl = !cw[0];
            rd(2'd3, r); check("R10 ctrl readback", r, cw);
            check("R2 a_oe", {7'd0, a_oe}, {7'd0, oa});
            check("R2 b_oe", {7'd0, b_oe}, {7'd0, ob});
            check("R2 c_oe", c_oe, {{4{ocu}}, {4{ocl}}});
            check("R5 b cleared", b_out, 8'h00);
            ea = 8'h11 + k[7:0]; eb = 8'hC3 ^ k[7:0]; ec = 8'h3C + (k[7:0] << 1);
            a_in = ~ea; b_in = ~eb; c_in = 8'hA5 ^ k[7:0];
            wr(2'd0, ea); wr(2'd1, eb); wr(2'd2, ec);
            check("R1 a_out", a_out, ea);
            check("R1 b_out", b_out, eb);
            check("R1 c_out", c_out, ec);
            rd(2'd0, r); check("R6 read A", r, oa ? ea : a_in);
            rd(2'd1, r); check("R6 read B", r, ob ? eb : b_in);
            rd(2'd2, r);
            check("R6 read C", r, {ocu ? ec[7:4] : c_in[7:4], ocl ? ec[3:0] : c_in[3:0]});
        end

        // R3 single-bit commands, all 16
        wr(2'd3, 8'h80);
        wr(2'd2, 8'h00);
        pc_m = 8'h00;
        for (int s = 0; s < 16; s++) begin
            wr(2'd3, s[7:0]);
            pc_m[s[3:1]] = s[0];
            check("R3 c_out bit", c_out, pc_m);
            check("R3 c_oe kept", c_oe, 8'hFF);
            rd(2'd3, r); check("R3 ctrl kept", r, 8'h80);
        end
        wr(2'd3, 8'h0F); wr(2'd3, 8'h07); wr(2'd3, 8'h0A);
        check("R3 mixed", c_out, 8'h80 | 8'h08 | pc_m[6:0] & 8'h7F & ~8'h20 | 8'h00 ? ((pc_m | 8'h88) & ~8'h20) : 8'h00);

        // R8 write with chip select high
        wr(2'd0, 8'h12);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
        @(negedge clk); wr_n = 1'b1;
        check("R8 cs high ignored", a_out, 8'h12);

        // R9 held write strobe captured once
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd1; din = 8'h34;
        @(negedge clk); din = 8'h99;
        @(negedge clk); addr = 2'd0; din = 8'h77;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
        check("R9 first capture", b_out, 8'h34);
        check("R9 no recapture", a_out, 8'h12);

        // R7 dout zero when rd low but cs high
        @(negedge clk);
        rd_n = 1'b0; addr = 2'd3;
        #1 check("R7 cs high read", dout, 8'h00);
        rd_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule